// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Tokens

This block holds eight binary tokens that two agents, a left port and a right port, use to claim shared resources without bus arbitration or wait states. It sits beside a dual-port memory but stores nothing of the memory itself. Each port writes a token to request or release it. It reads a token to learn whether it holds it. A token is active low: a port that owns a token reads 0 from it, and every other view reads 1.

Each token has one request latch per side and a grant stage. The grant stage hands a free token to the side that asks first. If both sides ask in the same cycle, the left side wins. A request from the side that does not own the token is remembered. When the owner releases the token, it passes to the waiting side in the same cycle. A read captures the token state when the read starts, copies it onto every data bit and holds it until the read ends.

Every pin is a plain synchronous control or data pin sampled on the rising clock edge. There is no valid/ready handshake and no back-pressure: a write strobe held for N cycles is N identical writes, and reads never stall.

Top module: `sem_token_unit`

## Requirements
- R1: After synchronous reset (`rst` high), all request latches are 1 and every token is free, so both ports read all-ones from every token.
- R2: The token index is address bits [2:0]. Address bits [14:3] have no effect on which token is accessed.
- R3: A port that writes data bit 0 = 0 to a free token owns it from the next clock edge. The owner then reads all zeros and the other port reads all ones. A write from the non-owner cannot take the token away.
- R4: A 0 written by the non-owning port is held as a pending request. When the owner writes 1, the token passes to the waiting port at that same clock edge.
- R5: When the owner writes 1 and no request is pending, the token becomes free and both ports read all ones.
- R6: Only bit 0 of the write data is used. Bits [17:1] are ignored.
- R7: A read (select low, write strobe high, output enable low) captures the token value on the first edge it is active. It drives that value on all 18 data bits and holds it, even if the token changes, until select or output enable goes high.
- R8: If both ports request a free token at the same edge, the left port gets it. If the requests come at different edges, the earlier one wins.
- R9: An access is ignored when the memory chip enable is low and either byte-lane select is low. With chip enable low and both lanes deselected, the access proceeds.
- R10: A non-owner that writes 1 withdraws its pending request. A later release by the owner then leaves the token free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low |
| l_lane_n | input | 2 | Left byte-lane selects, active low |
| l_addr | input | 15 | Left address; bits [2:0] pick the token |
| l_wdata | input | 18 | Left write data; bit 0 used |
| l_rdata | output | 18 | Left read data, token value on all bits |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ce_n | input | 1 | Right memory chip enable, active low |
| r_lane_n | input | 2 | Right byte-lane selects, active low |
| r_addr | input | 15 | Right address; bits [2:0] pick the token |
| r_wdata | input | 18 | Right write data; bit 0 used |
| r_rdata | output | 18 | Right read data, token value on all bits |

## Verification
The tokens are driven with the following patterns, each chosen to separate one kind of fault:
- A lone request followed by a release, which separates a working grant from a stuck one.
- A request from the non-owner, followed by the owner's release. This shows whether the pending latch is honoured or dropped.
- Requests from both sides at the same edge, and requests at different edges. These separate the fixed tie-break from the first-come ordering.
- Writes with upper address bits and upper data bits set, which show whether only the low index bits and data bit 0 are used.
- A chip-enable-active write, which shows whether an illegal access is blocked.
- A release made during a long read, which shows whether the read data is frozen or tracks the live token.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_token.sv
module sem_token
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_l,
  input  logic bit_l,
  input  logic wr_r,
  input  logic bit_r,
  output logic own_l,
  output logic own_r
);
  // request latches are active low: 0 means this side wants the token
  logic   req_l_q, req_r_q;
  logic   req_l_d, req_r_d;
  owner_e owner_q, owner_d;

  assign req_l_d = wr_l ? bit_l : req_l_q;
  assign req_r_d = wr_r ? bit_r : req_r_q;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_FREE: begin
        if (!req_l_d)      owner_d = OWN_LEFT;
        else if (!req_r_d) owner_d = OWN_RIGHT;
      end
      OWN_LEFT: begin
        if (req_l_d) owner_d = req_r_d ? OWN_FREE : OWN_RIGHT;
      end
      OWN_RIGHT: begin
        if (req_r_d) owner_d = req_l_d ? OWN_FREE : OWN_LEFT;
      end
      default: owner_d = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_l_q <= 1'b1;
      req_r_q <= 1'b1;
      owner_q <= OWN_FREE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      owner_q <= owner_d;
    end
  end

  assign own_l = (owner_q == OWN_LEFT);
  assign own_r = (owner_q == OWN_RIGHT);

  AST_RESET_FREE: assert property (@(posedge clk) rst |=> (owner_q == OWN_FREE)); // R1
  AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_LEFT && !(wr_l && bit_l)) |=> (owner_q == OWN_LEFT)); // R3
  AST_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_LEFT && wr_l && bit_l && !req_r_q && !wr_r) |=> (owner_q == OWN_RIGHT)); // R4
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
    (owner_q == OWN_FREE && wr_l && !bit_l && wr_r && !bit_r) |=> (owner_q == OWN_LEFT)); // R8
endmodule

// File: rtl/sem_port.sv
module sem_port #(
  parameter int N_TOK = 8,
  parameter int AW    = 15,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sem_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             ce_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [N_TOK-1:0] own_mine,
  output logic [N_TOK-1:0] wr_en,
  output logic             wr_bit,
  output logic [DW-1:0]    rdata
);
  localparam int IW = $clog2(N_TOK);

  logic [IW-1:0] idx;
  logic          blocked, acc, wr_any, rd_act;
  logic          rd_act_q, rd_q;
  logic          unused_bits;

  assign idx         = addr[IW-1:0];
  assign unused_bits = ^{addr[AW-1:IW], wdata[DW-1:1]};
  assign blocked     = !ce_n && (lane_n != {LANES{1'b1}});
  assign acc         = !sem_n && !blocked;
  assign wr_any      = acc && !we_n;
  assign rd_act      = acc && we_n && !oe_n;
  assign wr_bit      = wdata[0];

  for (genvar g = 0; g < N_TOK; g++) begin : g_dec
    assign wr_en[g] = wr_any && (idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      rd_q     <= 1'b1;
    end else begin
      rd_act_q <= rd_act;
      if (rd_act && !rd_act_q) rd_q <= !own_mine[idx];
    end
  end

  assign rdata = {DW{rd_q}};

  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (rd_act && rd_act_q) |=> $stable(rd_q)); // R7
endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit #(
  parameter int N_TOK = 8,
  parameter int AW    = 15,
  parameter int DW    = 18,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l_sem_n,
  input  logic             l_we_n,
  input  logic             l_oe_n,
  input  logic             l_ce_n,
  input  logic [LANES-1:0] l_lane_n,
  input  logic [AW-1:0]    l_addr,
  input  logic [DW-1:0]    l_wdata,
  output logic [DW-1:0]    l_rdata,
  input  logic             r_sem_n,
  input  logic             r_we_n,
  input  logic             r_oe_n,
  input  logic             r_ce_n,
  input  logic [LANES-1:0] r_lane_n,
  input  logic [AW-1:0]    r_addr,
  input  logic [DW-1:0]    r_wdata,
  output logic [DW-1:0]    r_rdata
);
  logic [N_TOK-1:0] wr_en_l, wr_en_r, own_l, own_r;
  logic             bit_l, bit_r;

  sem_port #(.N_TOK(N_TOK), .AW(AW), .DW(DW), .LANES(LANES)) u_left (
    .clk(clk), .rst(rst), .sem_n(l_sem_n), .we_n(l_we_n), .oe_n(l_oe_n),
    .ce_n(l_ce_n), .lane_n(l_lane_n), .addr(l_addr), .wdata(l_wdata),
    .own_mine(own_l), .wr_en(wr_en_l), .wr_bit(bit_l), .rdata(l_rdata)
  );

  sem_port #(.N_TOK(N_TOK), .AW(AW), .DW(DW), .LANES(LANES)) u_right (
    .clk(clk), .rst(rst), .sem_n(r_sem_n), .we_n(r_we_n), .oe_n(r_oe_n),
    .ce_n(r_ce_n), .lane_n(r_lane_n), .addr(r_addr), .wdata(r_wdata),
    .own_mine(own_r), .wr_en(wr_en_r), .wr_bit(bit_r), .rdata(r_rdata)
  );

  for (genvar g = 0; g < N_TOK; g++) begin : g_tok
    sem_token u_tok (
      .clk(clk), .rst(rst),
      .wr_l(wr_en_l[g]), .bit_l(bit_l),
      .wr_r(wr_en_r[g]), .bit_r(bit_r),
      .own_l(own_l[g]), .own_r(own_r[g])
    );
  end

  AST_NEVER_SHARED: assert property (@(posedge clk) disable iff (rst)
    (own_l & own_r) == '0); // R3
endmodule

// File: tb/sem_token_unit_tb.sv
module sem_token_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        l_sem_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_ce_n = 1'b1;
  logic [1:0]  l_lane_n = 2'b11;
  logic [14:0] l_addr = '0;
  logic [17:0] l_wdata = '1;
  logic [17:0] l_rdata;
  logic        r_sem_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_ce_n = 1'b1;
  logic [1:0]  r_lane_n = 2'b11;
  logic [14:0] r_addr = '0;
  logic [17:0] r_wdata = '1;
  logic [17:0] r_rdata;

  int n_chk = 0;
  int n_bad = 0;
  localparam logic [17:0] ONES  = '1;
  localparam logic [17:0] ZEROS = '0;

  always #5 clk = ~clk;

  sem_token_unit u_dut (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_ce_n(l_ce_n),
    .l_lane_n(l_lane_n), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_ce_n(r_ce_n),
    .r_lane_n(r_lane_n), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    l_sem_n = 1; l_we_n = 1; l_oe_n = 1; l_ce_n = 1; l_lane_n = 2'b11;
    r_sem_n = 1; r_we_n = 1; r_oe_n = 1; r_ce_n = 1; r_lane_n = 2'b11;
  endtask

  // side 0 = left, 1 = right
  task automatic wr(input bit s, input logic [14:0] a, input logic [17:0] d,
                    input logic ce = 1'b1, input logic [1:0] ln = 2'b11);
    @(negedge clk);
    if (!s) begin l_sem_n = 0; l_we_n = 0; l_addr = a; l_wdata = d; l_ce_n = ce; l_lane_n = ln; end
    else    begin r_sem_n = 0; r_we_n = 0; r_addr = a; r_wdata = d; r_ce_n = ce; r_lane_n = ln; end
    @(negedge clk);
    idle_all();
  endtask

  task automatic wr_both(input logic [14:0] a, input logic [17:0] dl, input logic [17:0] dr);
    @(negedge clk);
    l_sem_n = 0; l_we_n = 0; l_addr = a; l_wdata = dl;
    r_sem_n = 0; r_we_n = 0; r_addr = a; r_wdata = dr;
    @(negedge clk);
    idle_all();
  endtask

  task automatic rd_begin(input bit s, input logic [14:0] a);
    @(negedge clk);
    if (!s) begin l_sem_n = 0; l_oe_n = 0; l_addr = a; end
    else    begin r_sem_n = 0; r_oe_n = 0; r_addr = a; end
    @(negedge clk);
  endtask

  task automatic rd_end();
    idle_all();
    @(negedge clk);
  endtask

  task automatic rd(input bit s, input logic [14:0] a, input string req, input logic [17:0] exp);
    rd_begin(s, a);
    chk(req, s ? r_rdata : l_rdata, exp);
    rd_end();
  endtask

  task automatic t_reset();
    rd(0, 15'd0, "R1 left reads free token", ONES);
    rd(1, 15'd0, "R1 right reads free token", ONES);
  endtask

  task automatic t_grant_release();
    wr(0, 15'd1, 18'h0);
    rd(0, 15'd1, "R3 owner reads 0", ZEROS);
    rd(1, 15'd1, "R3 other reads 1", ONES);
    wr(1, 15'd1, 18'h0);
    rd(1, 15'd1, "R4 pending right still reads 1", ONES);
    rd(0, 15'd1, "R3 owner keeps token", ZEROS);
    wr(0, 15'd1, 18'h1);
    rd(1, 15'd1, "R4 right gets token on release", ZEROS);
    rd(0, 15'd1, "R4 left reads 1 after handoff", ONES);
    wr(1, 15'd1, 18'h1);
    rd(0, 15'd1, "R5 free left", ONES);
    rd(1, 15'd1, "R5 free right", ONES);
  endtask

  task automatic t_withdraw();
    wr(0, 15'd4, 18'h0);
    wr(1, 15'd4, 18'h0);
    wr(1, 15'd4, 18'h1);
    rd(0, 15'd4, "R10 non-owner 1 leaves owner", ZEROS);
    wr(0, 15'd4, 18'h1);
    rd(1, 15'd4, "R10 withdrawn request not granted", ONES);
  endtask

  task automatic t_data_bit0();
    wr(0, 15'd2, 18'h3FFFE);
    rd(0, 15'd2, "R6 bit0=0 with upper ones requests", ZEROS);
    wr(0, 15'd2, 18'h00001);
    rd(0, 15'd2, "R6 bit0=1 with upper zeros releases", ONES);
  endtask

  task automatic t_index();
    wr(0, 15'h7FFB, 18'h0);
    rd(1, 15'h4003, "R2 right sees token 3 taken via high bits", ONES);
    rd(0, 15'd3, "R2 left owns token 3", ZEROS);
    rd(0, 15'd4, "R2 neighbour token 4 untouched", ONES);
    wr(0, 15'd3, 18'h1);
  endtask

  task automatic t_tie_and_order();
    wr_both(15'd6, 18'h0, 18'h0);
    rd(0, 15'd6, "R8 tie goes left", ZEROS);
    rd(1, 15'd6, "R8 tie right loses", ONES);
    wr(0, 15'd6, 18'h1);
    rd(1, 15'd6, "R8 loser pending gets token", ZEROS);
    wr(1, 15'd6, 18'h1);
    wr(1, 15'd7, 18'h0);
    wr(0, 15'd7, 18'h0);
    rd(1, 15'd7, "R8 earlier right wins", ZEROS);
    rd(0, 15'd7, "R8 later left waits", ONES);
    wr(1, 15'd7, 18'h1);
    wr(0, 15'd7, 18'h1);
  endtask

  task automatic t_frozen_read();
    wr(1, 15'd0, 18'h0);
    wr(0, 15'd0, 18'h0);
    rd_begin(0, 15'd0);
    chk("R7 read starts with 1 on all bits", l_rdata, ONES);
    // right releases while left keeps reading
    r_sem_n = 0; r_we_n = 0; r_addr = 15'd0; r_wdata = 18'h1;
    @(negedge clk);
    r_sem_n = 1; r_we_n = 1;
    @(negedge clk);
    chk("R7 read held during token change", l_rdata, ONES);
    rd_end();
    rd(0, 15'd0, "R7 new read sees ownership", ZEROS);
    wr(0, 15'd0, 18'h1);
  endtask

  task automatic t_chip_enable();
    wr(0, 15'd5, 18'h0, 1'b0, 2'b10);
    rd(1, 15'd5, "R9 blocked write no effect right", ONES);
    rd(0, 15'd5, "R9 blocked write no effect left", ONES);
    wr(0, 15'd5, 18'h0, 1'b0, 2'b11);
    rd(0, 15'd5, "R9 ce low lanes off is legal", ZEROS);
    wr(0, 15'd5, 18'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_grant_release();
    t_withdraw();
    t_data_bit0();
    t_index();
    t_tie_and_order();
    t_frozen_read();
    t_chip_enable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule